// File: doc/BRIEF.md
# Delayed Branch Retirement Arbiter

This block sits beside the issue stage of a wide, statically scheduled core. Each issued instruction carries up to four branch slots. Each slot has its own predicate, its own retirement delay and either a signed offset or a code pointer. The block evaluates every slot in the cycle the instruction issues and drops the slots whose predicate is false. It holds the others in a delay line until they fall due.

In any cycle, several branches may fall due together. Some come from the instruction issuing now with no delay, and others come from older instructions whose delay has just run out. The arbiter takes one winner: the smallest original delay wins, and among equal delays the highest slot number wins. The winner's target is registered as the next fetch address. Once control leaves the block, every other pending branch is discarded.

An offset target is the entry address of the extended basic block that issued the branch plus the sign-extended 32-bit offset. The entry address is the one present when the branch issued. A pointer target is used unchanged.

Top module: `br_arb_top`

## Requirements
- R1: While reset is high and in the first cycle after it falls, `redir_valid` is 0.
- R2: A satisfied branch with delay 0 raises `redir_valid` in the cycle after its instruction issues, for one cycle. The same branch issued on consecutive cycles redirects on every one of those cycles.
- R3: A satisfied branch with delay d (0 to 7) redirects exactly d+1 cycles after its issue cycle and not earlier.
- R4: A slot whose valid bit or predicate is 0 never causes a redirect, and its delay, offset and pointer have no effect.
- R5: Among branches due in the same cycle, the one with the smaller original delay wins. This holds whether or not the branches come from the same instruction, and whatever their slot numbers.
- R6: Among due branches with equal original delay, the higher slot index (slot 3 highest, slot 0 lowest) wins.
- R7: With `slot_ptr_mode` 0, the target is `blk_entry` plus the 32-bit offset sign-extended to 64 bits. An offset of 0 yields the entry address itself.
- R8: With `slot_ptr_mode` 1, the target is `slot_ptr` unchanged and the offset is ignored.
- R9: When a branch wins, every other pending branch is discarded. This includes the other slots of the winning instruction and of the instruction issuing in that cycle, so none of them redirects later.
- R10: Pending branches from different instructions retire in due-cycle order, not issue order. A pending branch is unaffected by later instructions whose slots are not satisfied.
- R11: An offset target uses the `blk_entry` value sampled in the branch's issue cycle, even if `blk_entry` changes before it retires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_vld | input | 4 | Slot holds a branch operation, one bit per slot |
| slot_pred | input | 4 | Predicate value per slot, 1 means satisfied |
| slot_dly | input | 4x3 | Retirement delay per slot, 0 to 7 |
| slot_ptr_mode | input | 4 | 1 selects the code-pointer target for the slot |
| slot_off | input | 4x32 | Signed offset per slot |
| slot_ptr | input | 4x64 | Code pointer per slot |
| blk_entry | input | 64 | Entry address of the issuing extended basic block |
| redir_valid | output | 1 | Next-fetch redirect in this cycle |
| redir_target | output | 64 | Redirect address, meaningful when `redir_valid` is 1 |

## Verification
Two functions can fall in the same cycle. A delayed branch from an older instruction can fall due at the same time as a branch of the current instruction, and these two must be arbitrated against each other rather than both honoured. The bench provokes this by issuing an instruction with a long delay and, one or more cycles later, another with a shorter delay, so that both land on the same cycle or the later one lands first. The scoreboard expects the shorter original delay to win, and then expects silence in the cycle where the loser would have retired.

// File: rtl/br_arb_pkg.sv
package br_arb_pkg;
    localparam int NSLOT = 4;
    localparam int AW    = 64;
    localparam int OFFW  = 32;
    localparam int MAXD  = 7;
    localparam int DW    = $clog2(MAXD + 1);
    localparam int SW    = (NSLOT > 1) ? $clog2(NSLOT) : 1;
    localparam int NCAND = 2 * NSLOT;

    typedef struct packed {
        logic          vld;
        logic [DW-1:0] dly;
        logic [SW-1:0] slot;
        logic [AW-1:0] tgt;
    } br_ent_t;

    // a outranks b: smaller original delay, then higher slot
    function automatic logic outranks(br_ent_t a, br_ent_t b);
        if (!a.vld) return 1'b0;
        if (!b.vld) return 1'b1;
        if (a.dly != b.dly) return a.dly < b.dly;
        return a.slot > b.slot;
    endfunction

    function automatic logic [AW-1:0] calc_target(
        logic [AW-1:0]   entry,
        logic [OFFW-1:0] off,
        logic            pmode,
        logic [AW-1:0]   ptr
    );
        if (pmode) return ptr;
        return entry + {{(AW-OFFW){off[OFFW-1]}}, off};
    endfunction
endpackage

// File: rtl/br_arb_issue.sv
module br_arb_issue
    import br_arb_pkg::*;
(
    input  logic [NSLOT-1:0]           slot_vld,
    input  logic [NSLOT-1:0]           slot_pred,
    input  logic [NSLOT-1:0][DW-1:0]   slot_dly,
    input  logic [NSLOT-1:0]           slot_ptr_mode,
    input  logic [NSLOT-1:0][OFFW-1:0] slot_off,
    input  logic [NSLOT-1:0][AW-1:0]   slot_ptr,
    input  logic [AW-1:0]              blk_entry,
    output br_ent_t [NSLOT-1:0]        ent
);
    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        always_comb begin
            ent[s].vld  = slot_vld[s] && slot_pred[s] && (slot_dly[s] <= DW'(MAXD));
            ent[s].dly  = slot_dly[s];
            ent[s].slot = SW'(s);
            ent[s].tgt  = calc_target(blk_entry, slot_off[s], slot_ptr_mode[s], slot_ptr[s]);
        end
    end
endmodule

// File: rtl/br_arb_queue.sv
module br_arb_queue
    import br_arb_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                flush,
    input  br_ent_t [NSLOT-1:0] ins,
    output br_ent_t [NSLOT-1:0] head,
    output logic                busy
);
    br_ent_t [MAXD-1:0][NSLOT-1:0] q;
    logic    [MAXD-1:0][NSLOT-1:0] occ;

    for (genvar j = 0; j < MAXD; j++) begin : g_stage
        for (genvar s = 0; s < NSLOT; s++) begin : g_slot
            logic lands;
            assign lands    = ins[s].vld && (ins[s].dly == DW'(j + 1));
            assign occ[j][s] = q[j][s].vld;

            always_ff @(posedge clk) begin
                if (rst || flush) begin
                    q[j][s] <= '0;
                end else if (lands) begin
                    // a newer entry due in the same cycle on the same slot
                    // has the smaller delay, so the older one can never win
                    q[j][s] <= ins[s];
                end else if (j == MAXD - 1) begin
                    q[j][s] <= '0;
                end else begin
                    q[j][s] <= q[(j == MAXD - 1) ? j : j + 1][s];
                end
            end

            if (j < MAXD - 1) begin : g_chk
                p_shift_keeps_r10: assert property (@(posedge clk) disable iff (rst)
                    (q[j+1][s].vld && !flush) |=> q[j][s].vld);
            end
        end
    end

    assign head = q[0];
    assign busy = |occ;
endmodule

// File: rtl/br_arb_pick.sv
module br_arb_pick
    import br_arb_pkg::*;
(
    input  br_ent_t [NCAND-1:0] cand,
    output br_ent_t             win
);
    always_comb begin
        win = '0;
        for (int i = 0; i < NCAND; i++) begin
            if (outranks(cand[i], win)) win = cand[i];
        end
    end
endmodule

// File: rtl/br_arb_top.sv
module br_arb_top
    import br_arb_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NSLOT-1:0]           slot_vld,
    input  logic [NSLOT-1:0]           slot_pred,
    input  logic [NSLOT-1:0][DW-1:0]   slot_dly,
    input  logic [NSLOT-1:0]           slot_ptr_mode,
    input  logic [NSLOT-1:0][OFFW-1:0] slot_off,
    input  logic [NSLOT-1:0][AW-1:0]   slot_ptr,
    input  logic [AW-1:0]              blk_entry,
    output logic                       redir_valid,
    output logic [AW-1:0]              redir_target
);
    br_ent_t [NSLOT-1:0] fresh;
    br_ent_t [NSLOT-1:0] head;
    br_ent_t [NCAND-1:0] cand;
    br_ent_t             win;
    logic                q_busy;
    logic                head_any;
    logic [NSLOT-1:0]    port_d0;
    logic [NSLOT-1:0]    head_vld;

    br_arb_issue u_issue (
        .slot_vld      (slot_vld),
        .slot_pred     (slot_pred),
        .slot_dly      (slot_dly),
        .slot_ptr_mode (slot_ptr_mode),
        .slot_off      (slot_off),
        .slot_ptr      (slot_ptr),
        .blk_entry     (blk_entry),
        .ent           (fresh)
    );

    br_arb_queue u_queue (
        .clk   (clk),
        .rst   (rst),
        .flush (win.vld),
        .ins   (fresh),
        .head  (head),
        .busy  (q_busy)
    );

    for (genvar s = 0; s < NSLOT; s++) begin : g_cand
        always_comb begin
            cand[s]         = head[s];
            cand[NSLOT + s] = fresh[s];
            cand[NSLOT + s].vld = fresh[s].vld && (fresh[s].dly == '0);
        end
        assign head_vld[s] = head[s].vld;
        assign port_d0[s]  = slot_vld[s] && slot_pred[s] && (slot_dly[s] == '0);
    end

    assign head_any = |head_vld;

    br_arb_pick u_pick (
        .cand (cand),
        .win  (win)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            redir_valid  <= 1'b0;
            redir_target <= '0;
        end else begin
            redir_valid  <= win.vld;
            redir_target <= win.vld ? win.tgt : redir_target;
        end
    end

    p_d0_next_r2: assert property (@(posedge clk) disable iff (rst)
        (|port_d0) |=> redir_valid);

    p_head_retires_r3: assert property (@(posedge clk) disable iff (rst)
        head_any |=> redir_valid);

    p_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        (!head_any && !(|port_d0)) |=> !redir_valid);

    p_flush_empty_r9: assert property (@(posedge clk) disable iff (rst)
        redir_valid |-> !q_busy);
endmodule

// File: tb/sim_br_arb_top.sv
module sim_br_arb_top;
    import br_arb_pkg::*;

    logic                       clk = 1'b0;
    logic                       rst = 1'b1;
    logic [NSLOT-1:0]           s_vld;
    logic [NSLOT-1:0]           s_pred;
    logic [NSLOT-1:0][DW-1:0]   s_dly;
    logic [NSLOT-1:0]           s_pm;
    logic [NSLOT-1:0][OFFW-1:0] s_off;
    logic [NSLOT-1:0][AW-1:0]   s_ptr;
    logic [AW-1:0]              entry;
    logic                       redir_valid;
    logic [AW-1:0]              redir_target;

    int cyc = 0;
    int n_cmp = 0;
    int n_bad = 0;

    typedef struct {
        int          at;
        logic        vld;
        logic [63:0] tgt;
        string       tag;
    } exp_t;
    exp_t sb[$];

    localparam logic [63:0] E1 = 64'h0000_1000_0000_0000;
    localparam logic [63:0] E2 = 64'h0000_2000_0000_4000;
    localparam logic [63:0] E3 = 64'h0000_3000_0000_8000;
    localparam logic [63:0] P1 = 64'hFFFF_0000_1234_5678;
    localparam logic [63:0] P2 = 64'h0000_0ABC_DEF0_0000;
    localparam logic [63:0] P3 = 64'h7777_0000_0000_0040;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    br_arb_top u0 (
        .clk           (clk),
        .rst           (rst),
        .slot_vld      (s_vld),
        .slot_pred     (s_pred),
        .slot_dly      (s_dly),
        .slot_ptr_mode (s_pm),
        .slot_off      (s_off),
        .slot_ptr      (s_ptr),
        .blk_entry     (entry),
        .redir_valid   (redir_valid),
        .redir_target  (redir_target)
    );

    task automatic clear_in();
        s_vld = '0; s_pred = '0; s_dly = '0; s_pm = '0; s_off = '0; s_ptr = '0;
    endtask

    task automatic put(int s, int d, logic pm, logic [31:0] off, logic [63:0] ptr);
        s_vld[s]  = 1'b1;
        s_pred[s] = 1'b1;
        s_dly[s]  = DW'(d);
        s_pm[s]   = pm;
        s_off[s]  = off;
        s_ptr[s]  = ptr;
    endtask

    task automatic expect_at(int at, logic vld, logic [63:0] tgt, string tag);
        exp_t e;
        e.at = at; e.vld = vld; e.tgt = tgt; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic tick();
        @(negedge clk);
        clear_in();
    endtask

    task automatic gap(int n);
        repeat (n) tick();
    endtask

    // monitor: compare outputs against the scoreboard away from the edge
    always @(negedge clk) begin
        bit hit;
        if (!rst) begin
            hit = 1'b0;
            for (int i = sb.size() - 1; i >= 0; i--) begin
                if (sb[i].at == cyc) begin
                    hit = 1'b1;
                    n_cmp++;
                    if (redir_valid !== sb[i].vld ||
                        (sb[i].vld && redir_target !== sb[i].tgt)) begin
                        n_bad++;
                        $display("FAIL %s cyc=%0d actual vld=%0b tgt=%h expected vld=%0b tgt=%h",
                                 sb[i].tag, cyc, redir_valid, redir_target, sb[i].vld, sb[i].tgt);
                    end
                    sb.delete(i);
                end
            end
            if (!hit && redir_valid === 1'b1) begin
                n_cmp++;
                n_bad++;
                $display("FAIL R9 cyc=%0d actual vld=1 tgt=%h expected vld=0 (no redirect due)",
                         cyc, redir_target);
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog cyc=%0d actual running expected finished", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int t0;
        clear_in();
        entry = E1;
        repeat (3) @(negedge clk);
        n_cmp++;
        if (redir_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 actual vld=%0b expected vld=0 in reset", redir_valid);
        end
        rst = 1'b0;
        expect_at(cyc + 1, 1'b0, '0, "R1");
        gap(3);

        // R2: zero delay, then a one-instruction loop (R7 zero offset)
        put(0, 0, 1'b0, 32'h40, '0);
        expect_at(cyc + 1, 1'b1, E1 + 64'h40, "R2");
        tick();
        for (int k = 0; k < 3; k++) begin
            put(0, 0, 1'b0, 32'h0, '0);
            expect_at(cyc + 1, 1'b1, E1, "R2_R7");
            tick();
        end
        gap(10);

        // R3 + R8: delay 5, pointer mode, offset ignored
        put(2, 5, 1'b1, 32'h1234, P1);
        expect_at(cyc + 5, 1'b0, '0, "R3");
        expect_at(cyc + 6, 1'b1, P1, "R3_R8");
        tick();
        gap(10);

        // R3 + R7: maximum delay, negative offset
        put(3, 7, 1'b0, 32'hFFFF_FF00, '0);
        expect_at(cyc + 7, 1'b0, '0, "R3");
        expect_at(cyc + 8, 1'b1, E1 - 64'h100, "R3_R7");
        tick();
        gap(10);

        // R4: unsatisfied predicate and invalid slot
        s_vld[0] = 1'b1; s_pred[0] = 1'b0; s_off[0] = 32'h99;
        s_vld[1] = 1'b0; s_pred[1] = 1'b1; s_dly[1] = DW'(1); s_off[1] = 32'h77;
        expect_at(cyc + 1, 1'b0, '0, "R4");
        expect_at(cyc + 2, 1'b0, '0, "R4");
        tick();
        gap(10);

        // R6: equal delays, highest slot wins; others gone afterwards (R9)
        put(0, 2, 1'b0, 32'h10, '0);
        put(1, 2, 1'b0, 32'h20, '0);
        put(3, 2, 1'b0, 32'h30, '0);
        expect_at(cyc + 3, 1'b1, E1 + 64'h30, "R6");
        expect_at(cyc + 4, 1'b0, '0, "R9");
        tick();
        gap(10);

        // R5: same instruction, shorter delay wins over higher slot; R9 flush
        put(3, 2, 1'b0, 32'h30, '0);
        put(0, 1, 1'b0, 32'h10, '0);
        expect_at(cyc + 2, 1'b1, E1 + 64'h10, "R5");
        expect_at(cyc + 3, 1'b0, '0, "R9");
        tick();
        gap(10);

        // R5 across instructions: both due in the same cycle
        t0 = cyc;
        put(1, 4, 1'b1, '0, P2);
        tick();
        put(0, 3, 1'b0, 32'h50, '0);
        expect_at(t0 + 5, 1'b1, E1 + 64'h50, "R5");
        expect_at(t0 + 6, 1'b0, '0, "R9");
        tick();
        gap(10);

        // R10: later issue retires first, older one flushed (R9)
        t0 = cyc;
        put(2, 6, 1'b0, 32'h60, '0);
        tick();
        tick();
        put(0, 1, 1'b0, 32'h70, '0);
        expect_at(t0 + 4, 1'b1, E1 + 64'h70, "R10");
        expect_at(t0 + 7, 1'b0, '0, "R9");
        tick();
        gap(10);

        // R10: pending branch survives an unsatisfied later instruction
        t0 = cyc;
        put(1, 5, 1'b0, 32'h80, '0);
        tick();
        s_vld[3] = 1'b1; s_pred[3] = 1'b0; s_off[3] = 32'h5;
        tick();
        expect_at(t0 + 6, 1'b1, E1 + 64'h80, "R10");
        gap(10);

        // R11: entry sampled at issue
        t0 = cyc;
        entry = E2;
        put(1, 3, 1'b0, 32'h10, '0);
        tick();
        entry = E3;
        expect_at(t0 + 4, 1'b1, E2 + 64'h10, "R11");
        gap(10);
        entry = E1;

        // R9: same-instruction delayed slot dropped after zero-delay win
        put(0, 0, 1'b0, 32'h8, '0);
        put(1, 2, 1'b0, 32'h9, '0);
        expect_at(cyc + 1, 1'b1, E1 + 64'h8, "R9");
        expect_at(cyc + 3, 1'b0, '0, "R9");
        tick();
        gap(10);

        // R6 + R8: two zero-delay slots, higher one is a pointer
        put(1, 0, 1'b0, 32'h4, '0);
        put(2, 0, 1'b1, 32'h4, P3);
        expect_at(cyc + 1, 1'b1, P3, "R6_R8");
        tick();
        gap(12);

        while (sb.size() > 0) begin
            n_cmp++;
            n_bad++;
            $display("FAIL %s actual never sampled expected at cyc=%0d", sb[0].tag, sb[0].at);
            sb.delete(0);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule